// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a processor's private cache on a snooping bus and decides whether a store-conditional may complete. A load-linked arms a reservation: a single valid bit plus the address of the 64-byte block that was read. Three events cancel the reservation. The first is a snooped invalidation that names the reserved block. The second is eviction of that block from the cache. The third is a context switch. A later store-conditional succeeds only when the reservation is still armed and the store targets the reserved block. Only then is the processor given permission to put its ownership write on the bus. A failing store-conditional never gets that permission, so it cannot invalidate anyone else's copy.

Several processors may spin on the same lock and prefetch it exclusively at load-linked time. In that case they can keep stealing the block from each other. To break this, the monitor keeps a backoff window. Every failed store-conditional starts a wait of the current window length and then doubles the window, up to a cap. A successful store-conditional shrinks the window back to its minimum and ends any wait. The processor holds off its next attempt while the wait output is high.

Top module: `llsc_monitor`

## Requirements
- R1: After reset, `sc_resp_valid`, `sc_resp_ok`, `sc_bus_permit` and `retry_wait` are 0. No reservation is held, so a store-conditional issued before any load-linked fails.
- R2: A load-linked (`ll_valid`) arms the reservation and records the block of `ll_addr`. A store-conditional to the same block afterwards succeeds.
- R3: Block matching compares address bits 31 down to 6 only (64-byte block). Offsets inside the block never change the result. An address in a neighbouring block makes the store-conditional fail.
- R4: A snoop invalidation (`snoop_inv_valid`) whose address lies in the reserved block cancels the reservation. One to any other block leaves it armed.
- R5: A cache eviction report (`evict_valid`) whose address lies in the reserved block cancels the reservation. One to any other block leaves it armed.
- R6: A `ctx_switch` pulse cancels the reservation whatever its address.
- R7: The cycle after `sc_valid`, `sc_resp_valid` is 1 for exactly one cycle. `sc_resp_ok` is 1 in that cycle exactly when the reservation was armed and the store address is in the reserved block.
- R8: Every store-conditional, successful or not, disarms the reservation. A second store-conditional without a new load-linked fails.
- R9: `sc_bus_permit` is 1 only in the response cycle of a successful store-conditional. A failed store-conditional never raises it.
- R10: A cancel event in the same cycle as a store-conditional makes that store-conditional fail. A load-linked in the same cycle as a cancel event still leaves the reservation armed.
- R11: Each failed store-conditional raises `retry_wait` for W consecutive cycles, starting with its response cycle. W starts at 1, doubles after each failure, and never exceeds 256.
- R12: A successful store-conditional drops `retry_wait` in its response cycle and returns W to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_valid | input | 1 | Load-linked issued this cycle |
| ll_addr | input | 32 | Byte address of the load-linked |
| sc_valid | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | 32 | Byte address of the store-conditional |
| snoop_inv_valid | input | 1 | Snooped invalidation seen this cycle |
| snoop_inv_addr | input | 32 | Address of the snooped invalidation |
| evict_valid | input | 1 | Cache eviction of a block this cycle |
| evict_addr | input | 32 | Address of the evicted block |
| ctx_switch | input | 1 | Context-switch pulse |
| sc_resp_valid | output | 1 | Store-conditional result is valid |
| sc_resp_ok | output | 1 | Store-conditional succeeded |
| sc_bus_permit | output | 1 | The store may issue its bus write |
| retry_wait | output | 1 | Backoff in progress; hold the next attempt |

## Verification
The hardest state to reach from the ports is a backoff window at its cap. Getting there takes nine failed store-conditionals in a row with no success between them. The bench builds this up by issuing failing stores one after another. It counts the wait length after each one against the doubling series 1, 2, 4, …, 256, 256, then shows that a single success restores a one-cycle wait. Same-cycle collisions between a cancel event and a load-linked or store-conditional are set up directly. Each cancel source is swept against matching and non-matching blocks and several in-block offsets.

// File: rtl/llsc_pkg.sv
// Package llsc_pkg
// Shared constants and types for the reservation monitor.
// Assumes cancel sources are indexed densely from zero.
package llsc_pkg;
    localparam int KILL_SNOOP = 0;
    localparam int KILL_EVICT = 1;
    localparam int NUM_KILL   = 2;

    typedef struct packed {
        logic valid;
        logic ok;
    } sc_result_t;
endpackage

// File: rtl/llsc_block_match.sv
// Module llsc_block_match
// Compares two block addresses (byte offset already removed).
// Assumes both operands are the same width.
module llsc_block_match #(
    parameter int BLK_W = 26
) (
    input  logic [BLK_W-1:0] blk_a,
    input  logic [BLK_W-1:0] blk_b,
    output logic             same
);
    // Equality of block numbers
    always_comb same = (blk_a == blk_b);
endmodule

// File: rtl/llsc_lock_reg.sv
// Module llsc_lock_reg
// Holds the reservation bit and the reserved block number, applies
// cancel events and answers whether a store-conditional block hits.
// Assumes: set has priority over every clear; a cancel seen in the
// same cycle as a query makes the query miss.
module llsc_lock_reg #(
    parameter int BLK_W    = 26,
    parameter int NUM_SRC  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_req,
    input  logic [BLK_W-1:0]               set_blk,
    input  logic                           use_clr,
    input  logic                           ctx_clr,
    input  logic [NUM_SRC-1:0]             kill_valid,
    input  logic [NUM_SRC-1:0][BLK_W-1:0]  kill_blk,
    input  logic [BLK_W-1:0]               query_blk,
    output logic                           armed,
    output logic                           query_hit
);
    logic [BLK_W-1:0]   lock_blk;
    logic [NUM_SRC-1:0] kill_match;
    logic [NUM_SRC-1:0] kill_hit;
    logic               query_match;
    logic               cancel_now;

    // One comparator per cancel source
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_kill
        llsc_block_match #(.BLK_W(BLK_W)) u_cmp (
            .blk_a (kill_blk[i]),
            .blk_b (lock_blk),
            .same  (kill_match[i])
        );
        // Qualify each comparison with its valid
        always_comb kill_hit[i] = kill_valid[i] & kill_match[i];
    end

    llsc_block_match #(.BLK_W(BLK_W)) u_query (
        .blk_a (query_blk),
        .blk_b (lock_blk),
        .same  (query_match)
    );

    // Any event that cancels the reservation this cycle
    always_comb cancel_now = armed & ((|kill_hit) | ctx_clr);

    // Query hits only on a live, untouched reservation
    always_comb query_hit = armed & query_match & ~cancel_now;

    // Reservation bit and block register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            lock_blk <= '0;
        end else if (set_req) begin
            armed    <= 1'b1;
            lock_blk <= set_blk;
        end else if (use_clr || cancel_now || ctx_clr) begin
            armed    <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_backoff.sv
// Module llsc_backoff
// Exponential backoff after failed store-conditionals. A failure loads
// the wait counter with the current window and doubles the window up
// to CAP; a success resets the window and ends the wait.
// Assumes CAP is a power of two and MIN_WIN <= CAP.
module llsc_backoff #(
    parameter int CAP     = 256,
    parameter int MIN_WIN = 1,
    localparam int CW     = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_evt,
    input  logic          pass_evt,
    output logic          waiting,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CAP_V  = CW'(CAP);
    localparam logic [CW-1:0] HALF_V = CW'(CAP / 2);
    localparam logic [CW-1:0] MIN_V  = CW'(MIN_WIN);

    logic [CW-1:0] window;
    logic [CW-1:0] next_window;

    // Doubled window, saturating at the cap
    always_comb next_window = (window >= HALF_V) ? CAP_V : (window << 1);

    // Window and countdown registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= MIN_V;
            count  <= '0;
        end else if (pass_evt) begin
            window <= MIN_V;
            count  <= '0;
        end else if (fail_evt) begin
            count  <= window;
            window <= next_window;
        end else if (count != '0) begin
            count  <= count - 1'b1;
        end
    end

    // Waiting while the countdown is non-zero
    always_comb waiting = (count != '0);
endmodule

// File: rtl/llsc_monitor.sv
// Module llsc_monitor (top)
// Per-processor reservation monitor for load-linked/store-conditional
// on a snooping bus. Results are registered: a store-conditional in
// cycle N answers in cycle N+1. Only a successful store may drive a
// bus write; failures start exponential backoff.
// Assumes byte addresses and 2**BLK_OFS-byte blocks.
module llsc_monitor #(
    parameter int ADDR_W      = 32,
    parameter int BLK_OFS     = 6,
    parameter int BACKOFF_CAP = 256,
    parameter int BACKOFF_MIN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snoop_inv_valid,
    input  logic [ADDR_W-1:0] snoop_inv_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              ctx_switch,
    output logic              sc_resp_valid,
    output logic              sc_resp_ok,
    output logic              sc_bus_permit,
    output logic              retry_wait
);
    import llsc_pkg::*;

    localparam int BLK_W = ADDR_W - BLK_OFS;
    localparam int CNT_W = $clog2(BACKOFF_CAP + 1);

    logic [NUM_KILL-1:0]            kill_valid;
    logic [NUM_KILL-1:0][BLK_W-1:0] kill_blk;
    logic                           lock_flag;
    logic                           sc_hit;
    sc_result_t                     result_q;
    logic [CNT_W-1:0]               backoff_cnt;
    logic                           unused_low_bits;

    // Offset bits play no part in block matching
    assign unused_low_bits = ^{ll_addr[BLK_OFS-1:0], sc_addr[BLK_OFS-1:0],
                               snoop_inv_addr[BLK_OFS-1:0], evict_addr[BLK_OFS-1:0]};

    // Gather cancel sources into indexed vectors
    always_comb begin
        kill_valid[KILL_SNOOP] = snoop_inv_valid;
        kill_blk[KILL_SNOOP]   = snoop_inv_addr[ADDR_W-1:BLK_OFS];
        kill_valid[KILL_EVICT] = evict_valid;
        kill_blk[KILL_EVICT]   = evict_addr[ADDR_W-1:BLK_OFS];
    end

    llsc_lock_reg #(.BLK_W(BLK_W), .NUM_SRC(NUM_KILL)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (ll_valid),
        .set_blk    (ll_addr[ADDR_W-1:BLK_OFS]),
        .use_clr    (sc_valid),
        .ctx_clr    (ctx_switch),
        .kill_valid (kill_valid),
        .kill_blk   (kill_blk),
        .query_blk  (sc_addr[ADDR_W-1:BLK_OFS]),
        .armed      (lock_flag),
        .query_hit  (sc_hit)
    );

    llsc_backoff #(.CAP(BACKOFF_CAP), .MIN_WIN(BACKOFF_MIN)) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .fail_evt (sc_valid & ~sc_hit),
        .pass_evt (sc_valid & sc_hit),
        .waiting  (retry_wait),
        .count    (backoff_cnt)
    );

    // Register the store-conditional verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else begin
            result_q.valid <= sc_valid;
            result_q.ok    <= sc_valid & sc_hit;
        end
    end

    // Drive result and bus permission from the registered verdict
    always_comb begin
        sc_resp_valid = result_q.valid;
        sc_resp_ok    = result_q.ok;
        sc_bus_permit = result_q.valid & result_q.ok;
    end
endmodule

// File: rtl/llsc_monitor_chk.sv
// Module llsc_monitor_chk
// Property checker bound to llsc_monitor.
module llsc_monitor_chk #(
    parameter int CNT_W = 9,
    parameter int CAP   = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ll_valid,
    input logic             sc_valid,
    input logic             ctx_switch,
    input logic             sc_resp_valid,
    input logic             sc_resp_ok,
    input logic             sc_bus_permit,
    input logic             retry_wait,
    input logic             lock_flag,
    input logic [CNT_W-1:0] backoff_cnt
);
    AST_LL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ll_valid |=> lock_flag); // R2
    AST_CTX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_switch && !ll_valid) |=> !lock_flag); // R6
    AST_RESP_FOLLOWS_SC: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |=> sc_resp_valid); // R7
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |=> !sc_resp_valid); // R7
    AST_SC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !ll_valid) |=> !lock_flag); // R8
    AST_UNARMED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !lock_flag) |=> !sc_resp_ok); // R7
    AST_FAIL_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_resp_valid && !sc_resp_ok) |-> !sc_bus_permit); // R9
    AST_PERMIT_ONLY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        sc_bus_permit |-> sc_resp_valid); // R9
    AST_FAIL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_resp_valid && !sc_resp_ok) |-> retry_wait); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        backoff_cnt <= CNT_W'(CAP)); // R11
    AST_PASS_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        sc_resp_ok |-> !retry_wait); // R12
endmodule

bind llsc_monitor llsc_monitor_chk #(.CNT_W(CNT_W), .CAP(BACKOFF_CAP)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ll_valid      (ll_valid),
    .sc_valid      (sc_valid),
    .ctx_switch    (ctx_switch),
    .sc_resp_valid (sc_resp_valid),
    .sc_resp_ok    (sc_resp_ok),
    .sc_bus_permit (sc_bus_permit),
    .retry_wait    (retry_wait),
    .lock_flag     (lock_flag),
    .backoff_cnt   (backoff_cnt)
);

// File: tb/llsc_monitor_test.sv
// Bench llsc_monitor_test: self-checking sweeps over the monitor.
module llsc_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ll_valid = 1'b0, sc_valid = 1'b0;
    logic        snoop_inv_valid = 1'b0, evict_valid = 1'b0, ctx_switch = 1'b0;
    logic [31:0] ll_addr = '0, sc_addr = '0, snoop_inv_addr = '0, evict_addr = '0;
    logic        sc_resp_valid, sc_resp_ok, sc_bus_permit, retry_wait;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] BASE = 32'h1000_0040;

    always #10 clk = ~clk; // 50 MHz

    llsc_monitor uut (
        .clk(clk), .rst_n(rst_n),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .snoop_inv_valid(snoop_inv_valid), .snoop_inv_addr(snoop_inv_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .ctx_switch(ctx_switch),
        .sc_resp_valid(sc_resp_valid), .sc_resp_ok(sc_resp_ok),
        .sc_bus_permit(sc_bus_permit), .retry_wait(retry_wait)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one clock: inputs set now are seen at the next posedge,
    // outputs are read at the following negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        ll_valid = 0; sc_valid = 0; snoop_inv_valid = 0;
        evict_valid = 0; ctx_switch = 0;
    endtask

    task automatic do_ll(input logic [31:0] a);
        ll_valid = 1; ll_addr = a; step(); clear_in();
    endtask

    task automatic do_sc(input logic [31:0] a);
        sc_valid = 1; sc_addr = a; step(); clear_in();
    endtask

    // Count cycles retry_wait stays high, starting with the current one
    task automatic wait_len(output int n);
        n = 0;
        while (retry_wait && n < 1000) begin
            n++;
            step();
        end
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int n;
        int offs[4] = '{0, 1, 37, 63};
        @(negedge clk);
        repeat (3) step();
        chk("R1 resp_valid", sc_resp_valid, 0);
        chk("R1 resp_ok", sc_resp_ok, 0);
        chk("R1 permit", sc_bus_permit, 0);
        chk("R1 retry_wait", retry_wait, 0);
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", {sc_resp_valid, retry_wait}, 0);
        do_sc(BASE);
        chk("R1 sc before ll valid", sc_resp_valid, 1);
        chk("R1 sc before ll fails", sc_resp_ok, 0);
        wait_len(n);
        chk("R11 first window", n, 1);

        // R2/R3: offsets within block succeed, neighbours fail
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                do_ll(BASE + 32'(offs[i]));
                do_sc(BASE + 32'(offs[j]));
                chk("R3 in-block sc ok", sc_resp_ok, 1);
                chk("R9 permit on success", sc_bus_permit, 1);
                chk("R12 no wait on success", retry_wait, 0);
            end
        end
        for (int k = 0; k < 2; k++) begin
            do_ll(BASE);
            do_sc(k == 0 ? BASE + 32'd64 : BASE - 32'd1);
            chk("R3 neighbour block fails", sc_resp_ok, 0);
            chk("R9 no permit on fail", sc_bus_permit, 0);
            chk("R7 resp valid on fail", sc_resp_valid, 1);
        end
        do_ll(BASE); do_sc(BASE); // reset window
        chk("R2 ll then sc ok", sc_resp_ok, 1);
        step();
        chk("R7 resp is one cycle", sc_resp_valid, 0);

        // R4/R5: cancel sources, matching and not
        for (int src = 0; src < 2; src++) begin
            for (int m = 0; m < 2; m++) begin
                for (int o = 0; o < 4; o++) begin
                    logic [31:0] ka;
                    ka = (m == 1) ? BASE + 32'(offs[o]) : BASE + 32'(64 * (o + 1));
                    do_ll(BASE);
                    if (src == 0) begin snoop_inv_valid = 1; snoop_inv_addr = ka; end
                    else begin evict_valid = 1; evict_addr = ka; end
                    step(); clear_in();
                    do_sc(BASE + 32'd5);
                    if (src == 0) chk("R4 snoop cancel", sc_resp_ok, m == 1 ? 0 : 1);
                    else chk("R5 evict cancel", sc_resp_ok, m == 1 ? 0 : 1);
                    if (m == 1) chk("R9 cancelled no permit", sc_bus_permit, 0);
                    do_ll(BASE); do_sc(BASE); // keep window at minimum
                end
            end
        end

        // R6: context switch
        do_ll(BASE);
        ctx_switch = 1; step(); clear_in();
        do_sc(BASE);
        chk("R6 ctx switch cancels", sc_resp_ok, 0);
        do_ll(BASE); do_sc(BASE);

        // R8: second sc fails
        do_ll(BASE); do_sc(BASE);
        chk("R8 first sc ok", sc_resp_ok, 1);
        do_sc(BASE);
        chk("R8 second sc fails", sc_resp_ok, 0);
        do_ll(BASE); do_sc(BASE);

        // R10: same-cycle collisions
        do_ll(BASE);
        sc_valid = 1; sc_addr = BASE; snoop_inv_valid = 1; snoop_inv_addr = BASE + 32'd8;
        step(); clear_in();
        chk("R10 cancel with sc fails", sc_resp_ok, 0);
        ll_valid = 1; ll_addr = BASE; evict_valid = 1; evict_addr = BASE;
        ctx_switch = 1; step(); clear_in();
        do_sc(BASE);
        chk("R10 ll beats cancel", sc_resp_ok, 1);

        // R11: doubling series up to the cap
        for (int f = 0; f < 10; f++) begin
            int expw;
            expw = (f >= 8) ? 256 : (1 << f);
            do_sc(BASE);
            chk("R11 fail response", sc_resp_ok, 0);
            wait_len(n);
            chk("R11 window length", n, expw);
        end
        // R12: success mid-wait clears wait and resets window
        do_sc(BASE);
        repeat (5) step();
        chk("R11 still waiting", retry_wait, 1);
        ll_valid = 1; ll_addr = BASE; step(); clear_in();
        do_sc(BASE);
        chk("R12 success ok", sc_resp_ok, 1);
        chk("R12 wait dropped", retry_wait, 0);
        do_sc(BASE);
        wait_len(n);
        chk("R12 window back to 1", n, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule